// File: doc/BRIEF.md
# Multichannel DAC Serial Command Front End

This block is the digital front end of an eight-channel digital-to-analog converter whose channels do not all share one resolution. A host sends 32-bit frames over three wires: an active-low frame-sync line, a serial clock and a serial data line. The block oversamples these wires with its own system clock. It shifts one data bit in on each falling edge of the serial clock and decodes the completed frame into a 4-bit command and a 4-bit channel address.

Every channel has an input register and a DAC register. Commands can write the input register alone or update the DAC register from it. They can also write and update in one step, or write and then update every channel at once. Further commands set a per-channel auto-update mask, per-channel power modes, a clear-level selector and an internal-reference enable, and one command resets the whole block. The outputs show the current DAC register contents and the mode bits. The analog stage uses them.

Top module: `dac_serial_fe`

## Requirements
- R1: After the hardware reset every DAC code, every power mode, the auto-update mask, the clear selector and the reference enable read zero.
- R2: A frame begins when sync_n falls. Bits enter MSB first on each sclk falling edge, in this layout: bits 31:28 are ignored, 27:24 are the command, 23:20 are the address, 19:4 are the 16-bit data, and 3:0 are ignored. The command runs on the 32nd falling edge without waiting for sync_n to rise, and its outputs change within three clk cycles of that edge.
- R3: If sync_n rises before the 32nd falling edge, the frame is dropped and no state changes.
- R4: After a completed frame, further sclk edges are ignored while sync_n stays low. A new frame needs sync_n to go high and then low again.
- R5: Command 0000 writes the input register of the addressed channel and leaves its DAC register unchanged. Command 0001 copies the input register into the DAC register.
- R6: Command 0011 writes both the input and the DAC register of the addressed channel.
- R7: Command 0010 writes the addressed input register and then loads every DAC register from its input register.
- R8: Addresses 0000 to 0111 select channels 0 to 7. Address 1111 selects all channels, and addresses 1000 to 1110 select none.
- R9: Channels 2, 3, 4 and 5 are 12-bit. They keep data bits 15:4, right-aligned in their 16-bit output slot, and the upper four bits read zero. The other channels keep all 16 bits.
- R10: Command 0110 loads the auto-update mask from data bits 7:0, with bit i for channel i. A channel whose mask bit is set also updates its DAC register on every command-0000 write.
- R11: Command 0100 sets the 2-bit power mode of each channel whose bit is set in data bits 7:0 to data bits 9:8. Other channels keep their mode. Mode 00 means powered up, and channel i's mode is at pd_mode bits 2i+1:2i.
- R12: Command 0101 loads clr_sel from data bits 1:0. Command 1000 loads ref_en from data bit 0.
- R13: Command 0111 returns every register, including the input registers, to the R1 state.
- R14: Commands 1001 through 1111 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sclk |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Active-low frame sync, already synchronised |
| sclk | input | 1 | Serial clock, already synchronised |
| sdi | input | 1 | Serial data, already synchronised |
| dac_code | output | NUM_CH*16 | DAC register of channel i at bits 16i+15:16i |
| pd_mode | output | NUM_CH*2 | Power mode of channel i at bits 2i+1:2i |
| ldac_mask | output | NUM_CH | Auto-update mask |
| clr_sel | output | 2 | Clear-level selector |
| ref_en | output | 1 | Internal reference enable |

## Verification
The bench builds the block with its default parameters: eight channels, the mixed-width mask that makes channels 2 to 5 narrow, and a 12-bit narrow width. With these values every address code is reachable. That covers the unused codes 8 to 14 and the broadcast code, and a single broadcast write lands in both wide and narrow slots, which shows the truncation rule. Aborted frames, frames that finish while sync stays low, and every reserved command are all driven against the clock-by-clock model.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
    localparam int FRAME_W  = 32;
    localparam int CMD_LSB  = 24;
    localparam int ADDR_LSB = 20;
    localparam int DATA_LSB = 4;
    localparam int FIELD_W  = 4;
    localparam logic [FIELD_W-1:0] ADDR_ALL = 4'hF;

    typedef enum logic [FIELD_W-1:0] {
        OP_WR_IN      = 4'h0,
        OP_UPDATE     = 4'h1,
        OP_WR_UPD_ALL = 4'h2,
        OP_WR_UPD     = 4'h3,
        OP_POWER      = 4'h4,
        OP_CLR_LVL    = 4'h5,
        OP_AUTO_MASK  = 4'h6,
        OP_SOFT_RST   = 4'h7,
        OP_REF_CTRL   = 4'h8
    } op_e;
endpackage

// File: rtl/dac_fe_rx.sv
module dac_fe_rx
    import dac_fe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_n,
    input  logic               sclk,
    input  logic               sdi,
    output logic               frm_vld,
    output logic [FRAME_W-1:0] frm_bits
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               sync_q;
        logic               sclk_q;
        logic               active;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        logic               vld;
    } rx_t;

    rx_t st_d, st_q;
    logic sync_fall, sclk_fall;

    always_comb begin
        st_d        = st_q;
        st_d.vld    = 1'b0;
        st_d.sync_q = sync_n;
        st_d.sclk_q = sclk;
        sync_fall   = st_q.sync_q & ~sync_n;
        sclk_fall   = st_q.sclk_q & ~sclk;
        if (sync_n) begin
            st_d.active = 1'b0;
        end else if (sync_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && sclk_fall) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sdi};
            if (st_q.cnt == LAST_BIT) begin
                st_d.vld    = 1'b1;
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm_vld  = st_q.vld;
    assign frm_bits = st_q.shreg;
endmodule

// File: rtl/dac_fe_regs.sv
module dac_fe_regs
    import dac_fe_pkg::*;
#(
    parameter int                NUM_CH   = 8,
    parameter int                DATA_W   = 16,
    parameter int                NARROW_W = 12,
    parameter logic [NUM_CH-1:0] CH_WIDE  = 8'b1100_0011
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frm_vld,
    input  logic [FRAME_W-1:0]       frm_bits,
    output logic [NUM_CH*DATA_W-1:0] dac_code,
    output logic [NUM_CH*2-1:0]      pd_mode,
    output logic [NUM_CH-1:0]        ldac_mask,
    output logic [1:0]               clr_sel,
    output logic                     ref_en
);
    localparam int PAD_W = DATA_W - NARROW_W;

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] inp;
        logic [NUM_CH-1:0][DATA_W-1:0] dac;
        logic [NUM_CH-1:0][1:0]        pd;
        logic [NUM_CH-1:0]             ldac;
        logic [1:0]                    clr;
        logic                          ref_on;
    } bank_t;

    bank_t bk_d, bk_q;

    logic [FIELD_W-1:0] op_raw, addr;
    logic [DATA_W-1:0]  data;
    logic [NUM_CH-1:0]  sel;
    logic [DATA_W-1:0]  fit_val [NUM_CH];
    logic               unused_pad;

    assign op_raw     = frm_bits[CMD_LSB +: FIELD_W];
    assign addr       = frm_bits[ADDR_LSB +: FIELD_W];
    assign data       = frm_bits[DATA_LSB +: DATA_W];
    assign unused_pad = ^{frm_bits[FRAME_W-1:CMD_LSB+FIELD_W], frm_bits[DATA_LSB-1:0]};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign sel[g] = (addr == ADDR_ALL) || (addr == FIELD_W'(g));
        if (CH_WIDE[g]) begin : g_wide
            assign fit_val[g] = data;
        end else begin : g_narrow
            assign fit_val[g] = {{PAD_W{1'b0}}, data[DATA_W-1 -: NARROW_W]};
        end
    end

    always_comb begin
        bk_d = bk_q;
        if (frm_vld) begin
            case (op_e'(op_raw))
                OP_WR_IN: begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        if (sel[i]) begin
                            bk_d.inp[i] = fit_val[i];
                            if (bk_q.ldac[i]) bk_d.dac[i] = fit_val[i];
                        end
                    end
                end
                OP_UPDATE: begin
                    for (int i = 0; i < NUM_CH; i++)
                        if (sel[i]) bk_d.dac[i] = bk_q.inp[i];
                end
                OP_WR_UPD_ALL: begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        if (sel[i]) bk_d.inp[i] = fit_val[i];
                        bk_d.dac[i] = bk_d.inp[i];
                    end
                end
                OP_WR_UPD: begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        if (sel[i]) begin
                            bk_d.inp[i] = fit_val[i];
                            bk_d.dac[i] = fit_val[i];
                        end
                    end
                end
                OP_POWER: begin
                    for (int i = 0; i < NUM_CH; i++)
                        if (data[i]) bk_d.pd[i] = data[9:8];
                end
                OP_CLR_LVL:   bk_d.clr    = data[1:0];
                OP_AUTO_MASK: bk_d.ldac   = data[NUM_CH-1:0];
                OP_SOFT_RST:  bk_d        = '0;
                OP_REF_CTRL:  bk_d.ref_on = data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign dac_code  = bk_q.dac;
    assign pd_mode   = bk_q.pd;
    assign ldac_mask = bk_q.ldac;
    assign clr_sel   = bk_q.clr;
    assign ref_en    = bk_q.ref_on;
endmodule

// File: rtl/dac_serial_fe.sv
module dac_serial_fe
    import dac_fe_pkg::*;
#(
    parameter int                NUM_CH   = 8,
    parameter int                DATA_W   = 16,
    parameter int                NARROW_W = 12,
    parameter logic [NUM_CH-1:0] CH_WIDE  = 8'b1100_0011
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_n,
    input  logic                     sclk,
    input  logic                     sdi,
    output logic [NUM_CH*DATA_W-1:0] dac_code,
    output logic [NUM_CH*2-1:0]      pd_mode,
    output logic [NUM_CH-1:0]        ldac_mask,
    output logic [1:0]               clr_sel,
    output logic                     ref_en
);
    logic               frm_vld;
    logic [FRAME_W-1:0] frm_bits;

    dac_fe_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_n   (sync_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .frm_vld  (frm_vld),
        .frm_bits (frm_bits)
    );

    dac_fe_regs #(
        .NUM_CH   (NUM_CH),
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W),
        .CH_WIDE  (CH_WIDE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_vld   (frm_vld),
        .frm_bits  (frm_bits),
        .dac_code  (dac_code),
        .pd_mode   (pd_mode),
        .ldac_mask (ldac_mask),
        .clr_sel   (clr_sel),
        .ref_en    (ref_en)
    );
endmodule

// File: rtl/dac_serial_fe_chk.sv
module dac_serial_fe_chk
    import dac_fe_pkg::*;
#(
    parameter int                NUM_CH   = 8,
    parameter int                DATA_W   = 16,
    parameter int                NARROW_W = 12,
    parameter logic [NUM_CH-1:0] CH_WIDE  = 8'b1100_0011
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sync_n,
    input logic                     frm_vld,
    input logic [FRAME_W-1:0]       frm_bits,
    input logic [NUM_CH*DATA_W-1:0] dac_code,
    input logic [NUM_CH*2-1:0]      pd_mode,
    input logic [NUM_CH-1:0]        ldac_mask,
    input logic [1:0]               clr_sel,
    input logic                     ref_en
);
    function automatic logic [NUM_CH*DATA_W-1:0] narrow_hi_mask();
        logic [NUM_CH*DATA_W-1:0] m = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (!CH_WIDE[i])
                for (int b = NARROW_W; b < DATA_W; b++) m[i*DATA_W + b] = 1'b1;
        return m;
    endfunction

    localparam logic [NUM_CH*DATA_W-1:0] HI_MASK = narrow_hi_mask();

    logic [FIELD_W-1:0] op;
    logic               unused_bits;
    assign op          = frm_bits[CMD_LSB +: FIELD_W];
    assign unused_bits = ^{frm_bits[FRAME_W-1:CMD_LSB+FIELD_W], frm_bits[CMD_LSB-1:0]};

    p_abort_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> !$past(sync_n));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld);

    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> $stable(dac_code) && $stable(pd_mode) && $stable(ldac_mask));

    p_reserved_noop_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && op > 4'h8) |=> $stable(dac_code) && $stable(pd_mode)
            && $stable(ldac_mask) && $stable(clr_sel) && $stable(ref_en));

    p_soft_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && op == 4'h7) |=> (dac_code == '0) && (pd_mode == '0)
            && (ldac_mask == '0) && (clr_sel == 2'b00) && !ref_en);

    p_narrow_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code & HI_MASK) == '0);
endmodule

bind dac_serial_fe dac_serial_fe_chk #(
    .NUM_CH   (NUM_CH),
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .CH_WIDE  (CH_WIDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n    (sync_n),
    .frm_vld   (frm_vld),
    .frm_bits  (frm_bits),
    .dac_code  (dac_code),
    .pd_mode   (pd_mode),
    .ldac_mask (ldac_mask),
    .clr_sel   (clr_sel),
    .ref_en    (ref_en)
);

// File: tb/dac_serial_fe_bench.sv
module dac_serial_fe_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic [127:0] dac_code;
    logic [15:0]  pd_mode;
    logic [7:0]   ldac_mask;
    logic [1:0]   clr_sel;
    logic         ref_en;

    int checks = 0;
    int errors = 0;
    bit busy = 1'b1;
    bit done = 1'b0;

    logic [15:0] m_inp [8];
    logic [15:0] m_dac [8];
    logic [1:0]  m_pd  [8];
    logic [7:0]  m_ldac;
    logic [1:0]  m_clr;
    logic        m_ref;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_fe u_dac_serial_fe (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdi(sdi),
        .dac_code(dac_code), .pd_mode(pd_mode), .ldac_mask(ldac_mask),
        .clr_sel(clr_sel), .ref_en(ref_en)
    );

    function automatic logic [159:0] model_state();
        logic [127:0] d;
        logic [15:0]  p;
        for (int i = 0; i < 8; i++) begin
            d[i*16 +: 16] = m_dac[i];
            p[i*2 +: 2]   = m_pd[i];
        end
        return {5'b0, d, p, m_ldac, m_clr, m_ref};
    endfunction

    function automatic logic [159:0] dut_state();
        return {5'b0, dac_code, pd_mode, ldac_mask, clr_sel, ref_en};
    endfunction

    function automatic logic [15:0] fit(int ch, logic [15:0] v);
        if (ch >= 2 && ch <= 5) return {4'h0, v[15:4]};
        return v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 8; i++) begin
            m_inp[i] = '0; m_dac[i] = '0; m_pd[i] = '0;
        end
        m_ldac = '0; m_clr = '0; m_ref = 1'b0;
    endtask

    task automatic model_apply(logic [3:0] op, logic [3:0] addr, logic [15:0] data);
        for (int i = 0; i < 8; i++) begin
            bit hit = (addr == 4'hF) || (addr == 4'(i));
            case (op)
                4'h0: if (hit) begin
                    m_inp[i] = fit(i, data);
                    if (m_ldac[i]) m_dac[i] = m_inp[i];
                end
                4'h1: if (hit) m_dac[i] = m_inp[i];
                4'h2: if (hit) m_inp[i] = fit(i, data);
                4'h3: if (hit) begin m_inp[i] = fit(i, data); m_dac[i] = m_inp[i]; end
                4'h4: if (data[i]) m_pd[i] = data[9:8];
                default: ;
            endcase
        end
        if (op == 4'h2) for (int i = 0; i < 8; i++) m_dac[i] = m_inp[i];
        if (op == 4'h5) m_clr = data[1:0];
        if (op == 4'h6) m_ldac = data[7:0];
        if (op == 4'h7) model_clear();
        if (op == 4'h8) m_ref = data[0];
    endtask

    task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [3:0] op, logic [3:0] addr, logic [15:0] data,
                        int nbits = 32, bit exec = 1'b1, bit rearm = 1'b1, bit keep_low = 1'b0);
        logic [31:0] frame = {4'h0, op, addr, data, 4'h0};
        busy = 1'b1;
        if (rearm) begin
            sync_n = 1'b1; cyc(2);
            sync_n = 1'b0; cyc(2);
        end
        for (int i = 0; i < nbits; i++) begin
            sdi = frame[31-i];
            sclk = 1'b1; cyc(2);
            sclk = 1'b0; cyc(2);
        end
        cyc(3);
        if (exec) model_apply(op, addr, data);
        if (!keep_low) begin sync_n = 1'b1; cyc(2); end
        busy = 1'b0;
        cyc(1);
    endtask

    function automatic logic [159:0] ch(int i);
        return {144'b0, dac_code[i*16 +: 16]};
    endfunction

    always @(negedge clk) begin
        if (rst_n && !busy && !done)
            chk("R2 clock-by-clock state", dut_state(), model_state());
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [159:0] snap;
        model_clear();
        cyc(4);
        rst_n = 1'b1;
        busy = 1'b0;
        cyc(2);
        chk("R1 reset state", dut_state(), 160'b0);

        send(4'h0, 4'h0, 16'h1234);
        chk("R5 write input leaves dac", ch(0), 160'h0);
        send(4'h1, 4'h0, 16'h0000);
        chk("R5 update copies input", ch(0), 160'h1234);

        send(4'h3, 4'h1, 16'hBEEF);
        chk("R6 write and update", ch(1), 160'hBEEF);

        send(4'h3, 4'h2, 16'hABCD);
        chk("R9 narrow channel keeps top 12 bits", ch(2), 160'h0ABC);

        send(4'h3, 4'h7, 16'h8001);
        chk("R2 MSB-first field layout", ch(7), 160'h8001);

        send(4'h0, 4'h6, 16'h5555);
        send(4'h0, 4'h3, 16'hFFF0);
        send(4'h2, 4'h7, 16'h7777);
        chk("R7 update all ch6", ch(6), 160'h5555);
        chk("R7 update all ch3", ch(3), 160'h0FFF);
        chk("R7 update all ch7", ch(7), 160'h7777);

        send(4'h3, 4'hF, 16'h4321);
        chk("R8 broadcast wide ch0", ch(0), 160'h4321);
        chk("R8 broadcast narrow ch4", ch(4), 160'h0432);
        send(4'h3, 4'h9, 16'h9999);
        chk("R8 unused address selects none", dut_state(), model_state());
        chk("R8 unused address ch0 kept", ch(0), 160'h4321);

        send(4'h6, 4'h0, 16'h0021);
        chk("R10 mask load", {152'b0, ldac_mask}, 160'h21);
        send(4'h0, 4'h5, 16'h1110);
        chk("R10 masked channel auto-updates", ch(5), 160'h0111);
        send(4'h0, 4'h1, 16'h2222);
        chk("R10 unmasked channel holds dac", ch(1), 160'h4321);

        send(4'h4, 4'h0, 16'h0205);
        chk("R11 power modes set", {144'b0, pd_mode}, 160'h0022);
        send(4'h4, 4'h0, 16'h0001);
        chk("R11 power up ch0", {144'b0, pd_mode}, 160'h0020);

        send(4'h5, 4'h0, 16'h0003);
        chk("R12 clear selector", {158'b0, clr_sel}, 160'h3);
        send(4'h8, 4'h0, 16'h0001);
        chk("R12 reference enable", {159'b0, ref_en}, 160'h1);

        snap = dut_state();
        for (int op = 9; op < 16; op++) send(4'(op), 4'hF, 16'hFFFF);
        chk("R14 reserved commands inert", dut_state(), snap);

        send(4'h3, 4'h0, 16'hDEAD, 20, 1'b0);
        chk("R3 short frame dropped", ch(0), 160'h4321);
        send(4'h3, 4'h0, 16'hDEAD, 31, 1'b0);
        chk("R3 31-bit frame dropped", ch(0), 160'h4321);

        send(4'h3, 4'h0, 16'h0F0F, 32, 1'b1, 1'b1, 1'b1);
        chk("R2 runs with sync still low", ch(0), 160'h0F0F);
        send(4'h3, 4'h0, 16'hAAAA, 32, 1'b0, 1'b0, 1'b0);
        chk("R4 clocks ignored until re-arm", ch(0), 160'h0F0F);
        send(4'h3, 4'h0, 16'h5A5A);
        chk("R4 re-armed frame accepted", ch(0), 160'h5A5A);

        send(4'h7, 4'h0, 16'h0000);
        chk("R13 soft reset", dut_state(), 160'b0);
        send(4'h1, 4'hF, 16'h0000);
        chk("R13 input registers cleared", dut_state(), 160'b0);

        cyc(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule